// File: doc/BRIEF.md
# Configurable Serial Shift Slice

This block is one data lane of a serial general-purpose I/O engine. A 32-bit data register shifts right on every accepted shift clock. New input bits enter at the most significant end, and the low byte is always presented on a parallel output. A nine-bit configuration word sets the lane's behaviour:

- how many bits move per shift clock: 1, 2, 4 or 8;
- where the shift clock comes from: a reloading internal down-counter, or an external clock input sampled on a chosen edge;
- the polarity of the clock output;
- the polarity of the qualifier that gates shifting;
- whether the lane captures words or pattern-matches them;
- which condition on input bit 0 raises an interrupt.

In capture operation, every time a full word of 32 bits has been shifted the lane copies the data register into a shadow register and pulses an exchange interrupt. In match operation it compares the data register with a pattern register after every shift, using a mask to choose which bits take part. It pulses a match interrupt on equality, and it never performs an exchange.

A small state machine sequences the post-shift work. Its states are:

- **ST_FILL**: bits are accumulating.
- **ST_SWAP**: one cycle in which the shadow copy is made and the exchange interrupt is high.
- **ST_CMP**: one cycle in which the match result is presented.

Its transitions are:

- An accepted shift in match operation goes to ST_CMP, from any state.
- Otherwise, a shift that completes a word goes to ST_SWAP.
- Every other cycle returns to ST_FILL.

Shifts may arrive in any state, including back to back.

Top module: `shift_slice`

## Requirements
- R1: Register port addresses: 0 configuration, 1 counter preload, 2 data, 3 shadow (read-only), 4 pattern, 5 mask. Reads are combinational, and other addresses read as zero. Configuration bit positions are:
  - bit 0: match operation;
  - bit 1: falling capture edge;
  - bit 2: external clock source;
  - bit 3: invert clock output;
  - bits 5:4: input-bit interrupt condition;
  - bits 7:6: shift width;
  - bit 8: invert qualifier.

  All registers reset to zero, and configuration bits 31:9 read as zero.
- R2: The width field selects how many bits enter per accepted shift: 0 selects 1 bit, 1 selects 2, 2 selects 4 and 3 selects 8. The bits come from the low end of `din_i` and are inserted at the top while the register shifts right. `dout_o` always equals data bits 7:0.
- R3: With the internal source selected, the down-counter emits a tick when it is zero and reloads the preload value, so ticks repeat every preload+1 cycles. Writing the preload also loads the counter.
- R4: With the external source selected, `ext_clk_i` is synchronised. Its rising edges give ticks when the capture-edge bit is 0, and its falling edges give ticks when that bit is 1.
- R5: `sclk_o` is high for each tick cycle and low otherwise, or the inverse of that when the inversion bit is set.
- R6: A tick shifts only when `qual_i` XOR the qualifier-inversion bit is 1. A data-register write in the same cycle takes priority over a shift.
- R7: A bit counter sums the shifted bits and is cleared by a data write. The cycle after the shift that brings it to 32, `exch_irq_o` is high for one cycle and the shadow register takes the data register.
- R8: In match operation, the cycle after each shift `match_irq_o` is high if ((data XOR pattern) AND mask) is zero; a mask bit of 1 means the bit is compared. No exchange happens in match operation.
- R9: `bit_irq_o` is registered, one cycle after the sampled `din_i[0]`. Condition 0 raises it on a rising edge, 1 on a falling edge, 2 while the bit is low and 3 while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for read and write |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Register read data |
| din_i | input | 8 | Parallel/serial data input |
| dout_o | output | 8 | Low byte of the data register |
| ext_clk_i | input | 1 | External shift clock |
| qual_i | input | 1 | Shift qualifier |
| sclk_o | output | 1 | Generated shift clock |
| exch_irq_o | output | 1 | Word exchange pulse |
| match_irq_o | output | 1 | Pattern match pulse |
| bit_irq_o | output | 1 | Input-bit condition interrupt |

## Verification
Some properties are checked by assertions on every cycle:

- the down-counter decrements and reloads;
- the data register is unchanged while the qualifier is inactive;
- the shadow register takes the data value in the cycle after ST_SWAP;
- no exchange follows a cycle spent in match operation.

The bench scenarios show what only chosen stimulus reveals:

- the inserted bit pattern for each of the four widths;
- exchange firing exactly at the 32nd bit and not at the 31st;
- masked and exact matches;
- capture-edge selection on the external clock;
- clock output polarity;
- the four input-bit interrupt conditions.

// File: rtl/slice_pkg.sv
package slice_pkg;
    localparam int CFG_W    = 9;
    localparam int MAX_STEP = 8;

    // field order equals bit order of the configuration word (bit 0 last)
    typedef struct packed {
        logic       inv_qual;   // bit 8
        logic [1:0] width_sel;  // bits 7:6
        logic [1:0] bit_cond;   // bits 5:4
        logic       inv_sclk;   // bit 3
        logic       ext_src;    // bit 2
        logic       fall_edge;  // bit 1
        logic       match_en;   // bit 0
    } slice_cfg_t;

    typedef enum logic [1:0] {
        ST_FILL = 2'd0,
        ST_SWAP = 2'd1,
        ST_CMP  = 2'd2
    } slice_state_e;
endpackage

// File: rtl/slice_clkgen.sv
module slice_clkgen #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] preload_i,
    input  logic             ld_i,
    input  logic [CNT_W-1:0] ld_val_i,
    input  logic             ext_sel_i,
    input  logic             fall_i,
    input  logic             ext_clk_i,
    output logic             tick_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [2:0]       sync_q;
    logic             int_tick, ext_tick;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            cnt_q <= '0;
        else if (ld_i)          cnt_q <= ld_val_i;
        else if (cnt_q == '0)   cnt_q <= preload_i;
        else                    cnt_q <= cnt_q - 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[1:0], ext_clk_i};
    end

    assign int_tick = (cnt_q == '0);
    assign ext_tick = fall_i ? (!sync_q[1] && sync_q[2]) : (sync_q[1] && !sync_q[2]);
    assign tick_o   = ext_sel_i ? ext_tick : int_tick;

    AST_CNT_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ld_i && cnt_q == '0) |=> cnt_q == $past(preload_i)); // R3
    AST_CNT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ld_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1); // R3
endmodule

// File: rtl/slice_bitdet.sv
module slice_bitdet (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] cond_i,
    input  logic       bit_i,
    output logic       irq_o
);
    logic prev_q, hit;

    always_comb begin
        unique case (cond_i)
            2'd0:    hit = bit_i && !prev_q;
            2'd1:    hit = !bit_i && prev_q;
            2'd2:    hit = !bit_i;
            default: hit = bit_i;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_q <= 1'b0;
            irq_o  <= 1'b0;
        end else begin
            prev_q <= bit_i;
            irq_o  <= hit;
        end
    end
endmodule

// File: rtl/shift_slice.sv
module shift_slice
    import slice_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic [7:0]        din_i,
    output logic [7:0]        dout_o,
    input  logic              ext_clk_i,
    input  logic              qual_i,
    output logic              sclk_o,
    output logic              exch_irq_o,
    output logic              match_irq_o,
    output logic              bit_irq_o
);
    localparam int BC_W = $clog2(DATA_W);   // DATA_W must be a power of two

    slice_cfg_t          cfg_q;
    logic [CNT_W-1:0]    preload_q;
    logic [DATA_W-1:0]   data_q, shadow_q, pattern_q, mask_q, data_nx;
    logic [BC_W-1:0]     bitcnt_q;
    logic [BC_W:0]       bit_sum, step;
    logic                tick, qual_act, shift_en, wrap, hit;
    logic                cfg_wr, pre_wr, data_wr;
    slice_state_e        state_q, state_nx;

    assign cfg_wr  = wr_en_i && addr_i == ADDR_W'(0);
    assign pre_wr  = wr_en_i && addr_i == ADDR_W'(1);
    assign data_wr = wr_en_i && addr_i == ADDR_W'(2);

    slice_clkgen #(.CNT_W(CNT_W)) i_clkgen (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .preload_i (preload_q),
        .ld_i      (pre_wr),
        .ld_val_i  (wr_data_i[CNT_W-1:0]),
        .ext_sel_i (cfg_q.ext_src),
        .fall_i    (cfg_q.fall_edge),
        .ext_clk_i (ext_clk_i),
        .tick_o    (tick)
    );

    slice_bitdet i_bitdet (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cond_i (cfg_q.bit_cond),
        .bit_i  (din_i[0]),
        .irq_o  (bit_irq_o)
    );

    assign qual_act = qual_i ^ cfg_q.inv_qual;
    assign shift_en = tick && qual_act && !data_wr;
    assign step     = (BC_W+1)'(1) << cfg_q.width_sel;
    assign bit_sum  = {1'b0, bitcnt_q} + step;
    assign wrap     = bit_sum[BC_W];
    assign hit      = ((data_q ^ pattern_q) & mask_q) == '0;

    always_comb begin
        unique case (cfg_q.width_sel)
            2'd0:    data_nx = {din_i[0],   data_q[DATA_W-1:1]};
            2'd1:    data_nx = {din_i[1:0], data_q[DATA_W-1:2]};
            2'd2:    data_nx = {din_i[3:0], data_q[DATA_W-1:4]};
            default: data_nx = {din_i[7:0], data_q[DATA_W-1:8]};
        endcase
    end

    // register file
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q     <= '0;
            preload_q <= '0;
            pattern_q <= '0;
            mask_q    <= '0;
        end else if (wr_en_i) begin
            unique case (addr_i)
                ADDR_W'(0): cfg_q     <= wr_data_i[CFG_W-1:0];
                ADDR_W'(1): preload_q <= wr_data_i[CNT_W-1:0];
                ADDR_W'(4): pattern_q <= wr_data_i;
                ADDR_W'(5): mask_q    <= wr_data_i;
                default:    ;
            endcase
        end
    end

    // data path: data register, bit counter, shadow
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            data_q   <= '0;
            bitcnt_q <= '0;
            shadow_q <= '0;
        end else begin
            if (data_wr) begin
                data_q   <= wr_data_i;
                bitcnt_q <= '0;
            end else if (shift_en) begin
                data_q   <= data_nx;
                bitcnt_q <= bit_sum[BC_W-1:0];
            end
            if (state_q == ST_SWAP) shadow_q <= data_q;
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_FILL;
        else         state_q <= state_nx;
    end

    always_comb begin
        state_nx = ST_FILL;
        if (shift_en) begin
            if (cfg_q.match_en) state_nx = ST_CMP;
            else if (wrap)      state_nx = ST_SWAP;
        end
    end

    // outputs
    always_comb begin
        exch_irq_o  = 1'b0;
        match_irq_o = 1'b0;
        unique case (state_q)
            ST_SWAP: exch_irq_o  = 1'b1;
            ST_CMP:  match_irq_o = hit;
            default: ;
        endcase
    end

    assign sclk_o = tick ^ cfg_q.inv_sclk;
    assign dout_o = data_q[7:0];

    always_comb begin
        unique case (addr_i)
            ADDR_W'(0): rd_data_o = {{(DATA_W-CFG_W){1'b0}}, cfg_q};
            ADDR_W'(1): rd_data_o = {{(DATA_W-CNT_W){1'b0}}, preload_q};
            ADDR_W'(2): rd_data_o = data_q;
            ADDR_W'(3): rd_data_o = shadow_q;
            ADDR_W'(4): rd_data_o = pattern_q;
            ADDR_W'(5): rd_data_o = mask_q;
            default:    rd_data_o = '0;
        endcase
    end

    AST_HOLD_UNQUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!qual_act && !data_wr) |=> $stable(data_q)); // R6
    AST_SWAP_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_SWAP) |=> shadow_q == $past(data_q)); // R7
    AST_MATCH_NO_SWAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_q.match_en |=> !exch_irq_o); // R8
endmodule

// File: tb/test_shift_slice.sv
`timescale 1ns/1ps
module test_shift_slice;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic [7:0]  din = '0, dout;
    logic        ext_clk = 1'b0, qual = 1'b0;
    logic        sclk, exch_irq, match_irq, bit_irq;
    int          n_chk = 0, n_fail = 0;
    int          n_exch = 0, n_match = 0, n_sclk = 0;

    always #2.5 clk = ~clk;

    shift_slice i_shift_slice (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
        .wr_data_i(wdata), .rd_data_o(rdata), .din_i(din), .dout_o(dout),
        .ext_clk_i(ext_clk), .qual_i(qual), .sclk_o(sclk),
        .exch_irq_o(exch_irq), .match_irq_o(match_irq), .bit_irq_o(bit_irq)
    );

    always @(negedge clk) begin
        if (exch_irq)  n_exch++;
        if (match_irq) n_match++;
        if (sclk)      n_sclk++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata;
    endtask

    // qualifier active (with inversion off) for n system cycles
    task automatic shift_n(input int n, input logic [7:0] d);
        @(negedge clk);
        din = d; qual = 1'b1;
        repeat (n) @(negedge clk);
        qual = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int a = 0; a < 6; a++) begin
            rd(a[2:0], v); check("R1 reset", v, 32'h0);
        end
        check("R7 exch idle", {31'b0, exch_irq}, 32'h0);
        check("R8 match idle", {31'b0, match_irq}, 32'h0);
    endtask

    task automatic t_cfg;
        logic [31:0] v;
        wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, v); check("R1 cfg reserved", v, 32'h1FF);
        wr(3'd3, 32'h1234_5678); rd(3'd3, v); check("R1 shadow ro", v, 32'h0);
        wr(3'd0, 32'h0);
    endtask

    task automatic t_width;
        logic [31:0] v, e;
        for (int m = 0; m < 4; m++) begin
            wr(3'd0, m << 6); wr(3'd2, 32'h0);
            shift_n(3, 8'hFF);
            rd(3'd2, v);
            e = ~(32'hFFFF_FFFF >> (3 * (1 << m)));
            check("R2 width", v, e);
        end
        wr(3'd2, 32'h1234_5678); #1;
        check("R2 dout", {24'h0, dout}, 32'h78);
        wr(3'd0, 32'h0);
    endtask

    task automatic t_qual;
        logic [31:0] v;
        wr(3'd2, 32'h0); din = 8'hFF;
        repeat (5) @(negedge clk);
        rd(3'd2, v); check("R6 unqualified hold", v, 32'h0);
        wr(3'd0, 32'h100);
        repeat (2) @(negedge clk);
        wr(3'd0, 32'h0);
        rd(3'd2, v);
        check("R6 inverted qualifier shifts", {31'b0, v[31]}, 32'h1);
    endtask

    task automatic t_exchange;
        logic [31:0] v;
        int e0;
        wr(3'd0, 32'hC0); wr(3'd2, 32'h0);
        e0 = n_exch;
        @(negedge clk); din = 8'h11; qual = 1'b1;
        @(negedge clk); din = 8'h22;
        @(negedge clk); din = 8'h33;
        @(negedge clk); din = 8'h44;
        @(negedge clk); qual = 1'b0;
        repeat (3) @(negedge clk);
        rd(3'd3, v); check("R7 shadow bytes", v, 32'h4433_2211);
        check("R7 one exchange", n_exch - e0, 1);
        wr(3'd0, 32'h0); wr(3'd2, 32'h0);
        e0 = n_exch;
        shift_n(31, 8'h01); repeat (3) @(negedge clk);
        check("R7 no exchange at 31", n_exch - e0, 0);
        shift_n(1, 8'h01); repeat (3) @(negedge clk);
        check("R7 exchange at 32", n_exch - e0, 1);
        rd(3'd3, v); check("R7 shadow ones", v, 32'hFFFF_FFFF);
        wr(3'd0, 32'h40); wr(3'd2, 32'h0);
        e0 = n_exch;
        shift_n(16, 8'h02); repeat (3) @(negedge clk);
        check("R7 exchange 2-bit", n_exch - e0, 1);
        rd(3'd3, v); check("R7 shadow 2-bit", v, 32'hAAAA_AAAA);
        wr(3'd0, 32'h0);
    endtask

    task automatic t_match;
        int m0, e0;
        wr(3'd0, 32'hC1); wr(3'd4, 32'hDEAD_BEEF); wr(3'd5, 32'hFFFF_FFFF); wr(3'd2, 32'h0);
        m0 = n_match; e0 = n_exch;
        @(negedge clk); din = 8'hEF; qual = 1'b1;
        @(negedge clk); din = 8'hBE;
        @(negedge clk); din = 8'hAD;
        @(negedge clk); din = 8'hDE;
        @(negedge clk); qual = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 exact match", n_match - m0, 1);
        check("R8 no exchange", n_exch - e0, 0);
        wr(3'd4, 32'hAB00_0000); wr(3'd5, 32'hFF00_0000);
        m0 = n_match;
        shift_n(5, 8'hAB); repeat (3) @(negedge clk);
        check("R8 masked match", n_match - m0, 5);
        wr(3'd0, 32'h0);
    endtask

    task automatic t_counter;
        int s0;
        wr(3'd1, 32'd3);
        s0 = n_sclk;
        repeat (40) @(negedge clk);
        check("R3 tick period", n_sclk - s0, 10);
        wr(3'd1, 32'd100);
        @(negedge clk);
        check("R5 sclk low", {31'b0, sclk}, 32'h0);
        wr(3'd0, 32'h8);
        check("R5 sclk inverted", {31'b0, sclk}, 32'h1);
        wr(3'd0, 32'h0); wr(3'd1, 32'd0);
    endtask

    task automatic t_ext;
        logic [31:0] v;
        wr(3'd0, 32'h4); wr(3'd2, 32'h0);
        @(negedge clk); din = 8'hFF; qual = 1'b1;
        repeat (6) @(negedge clk);
        ext_clk = 1'b1; repeat (8) @(negedge clk);
        rd(3'd2, v); check("R4 rising edge", v, 32'h8000_0000);
        wr(3'd0, 32'h6);
        ext_clk = 1'b0; repeat (8) @(negedge clk);
        rd(3'd2, v); check("R4 falling edge", v, 32'hC000_0000);
        ext_clk = 1'b1; repeat (8) @(negedge clk);
        rd(3'd2, v); check("R4 rising ignored", v, 32'hC000_0000);
        qual = 1'b0;
        wr(3'd0, 32'h0);
    endtask

    task automatic t_bitirq;
        wr(3'd0, 32'h00); din = 8'h00; repeat (2) @(negedge clk);
        din = 8'h01; @(negedge clk);
        check("R9 rising", {31'b0, bit_irq}, 32'h1);
        @(negedge clk); check("R9 rising once", {31'b0, bit_irq}, 32'h0);
        wr(3'd0, 32'h10); din = 8'h00; @(negedge clk);
        check("R9 falling", {31'b0, bit_irq}, 32'h1);
        wr(3'd0, 32'h20); @(negedge clk);
        check("R9 low level", {31'b0, bit_irq}, 32'h1);
        wr(3'd0, 32'h30); @(negedge clk);
        check("R9 high level idle", {31'b0, bit_irq}, 32'h0);
        din = 8'h01; repeat (2) @(negedge clk);
        check("R9 high level", {31'b0, bit_irq}, 32'h1);
        wr(3'd0, 32'h0); din = 8'h00;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_cfg;
        t_width;
        t_qual;
        t_exchange;
        t_match;
        t_counter;
        t_ext;
        t_bitirq;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule